// File: doc/BRIEF.md
# Write-Status Operation Engine

This block runs the timed phase of a program or erase once a command decoder has finished with the command. A qualified write strobe, together with a start request, loads the operation type, the target address and the data byte. The engine then stays busy for a fixed number of clock cycles that depends on the operation type. When the interval ends it returns to read mode and raises a one-cycle completion pulse. While it is busy, the array drives the data it is given through the latched address and data outputs.

Reads go through the engine. When it is idle, a read returns the array byte unchanged. While it is busy, the top bit of a read is a polling bit. For a program, that bit is the inverse of the top bit of the byte being written. For an erase, it is zero. The next bit flips on every read, so software can watch it toggle until the operation ends. Writes are refused for a timed window after the supply-good input rises, and also after reset. Strobes that are too short are discarded. A low output enable blocks any write. Every duration is a parameter counted in clock cycles.

Top module: `wse_engine`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `rd_oe` and `rd_data` are all 0, and a read strobe has no effect.
- R2: Once `rst_n` is released, and again whenever `pwr_ok` has been low, no operation starts until `pwr_ok` has been high for `POR_CYC` cycles.
- R3: An operation starts at the first clock edge at which `we_n` is high, provided that `we_n` was sampled low on at least `WE_MIN_CYC` consecutive edges just before it, with `oe_n` high throughout. `start_req` must also be high at that edge. A shorter low run starts nothing.
- R4: If `oe_n` is low during the low run of `we_n`, or at the edge where `we_n` returns high, no operation starts.
- R5: `start_op` codes are 0 for byte program, 1 for sector erase and 2 for chip erase. `busy` stays high for exactly `PROG_CYC` cycles for a program and exactly `ERASE_CYC` cycles for either erase.
- R6: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low again.
- R7: A start attempt made while busy is ignored. `busy_addr` and `busy_data` keep the values latched at launch until the next launch.
- R8: During a program, bit 7 of a read returns the inverse of bit 7 of the latched data.
- R9: During an erase, bit 7 of a read returns 0.
- R10: While busy, bit 6 of a read returns 0 on the first read after launch and then flips on each later read. A launch clears it, even if a read falls on the launch edge.
- R11: A read taken while not busy, including one that falls on the launch edge, returns `arr_data` unchanged. While busy, bits 5..0 of a read come from `arr_data`.
- R12: A read strobe sampled at an edge makes `rd_oe` high for the next cycle, with `rd_data` valid in that cycle. Otherwise `rd_oe` is low.
- R13: `start_op` code 3 is reserved and starts nothing.
- R14: Pulling `rst_n` low during an operation aborts it. No `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; halts the engine |
| pwr_ok | input | 1 | Supply-good level; starts the write lockout window |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; a low level blocks writes |
| start_req | input | 1 | Decoder requests an operation at the strobe's end |
| start_op | input | 2 | Operation code: 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| start_addr | input | ADDR_W | Target address |
| start_data | input | DATA_W | Byte to program |
| rd_stb | input | 1 | Read strobe, one cycle |
| arr_data | input | DATA_W | Byte read from the array |
| rd_data | output | DATA_W | Read result: array byte or status |
| rd_oe | output | 1 | Read data valid / drive enable |
| busy | output | 1 | Timed operation in progress |
| done | output | 1 | One-cycle completion pulse |
| busy_addr | output | ADDR_W | Address latched at launch |
| busy_data | output | DATA_W | Data latched at launch |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a read and a launch. The bench raises `rd_stb` in the same cycle as the rising `we_n` of a qualified write. That read must return the plain array byte. The read that follows must show bit 6 at 0, even though the operation before it left the toggle at 1. The second pair is a read and completion. The bench counts cycles from launch and issues a read in the last cycle where `busy` is high. That read must still carry the polling pattern, and `done` must rise at the same edge. The queue-based scoreboard compares each read result in the order the reads were issued.

// File: rtl/wse_pkg.sv
package wse_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_RSVD   = 2'b11
    } wse_op_e;

endpackage

// File: rtl/wse_we_filter.sv
// Write strobe qualifier: counts consecutive low samples of we_n with oe_n
// high, and fires on the first high sample that follows a long enough run.
module wse_we_filter #(
    parameter int WE_MIN_CYC = 4,
    localparam int CW = $clog2(WE_MIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_fire
);

    typedef struct packed {
        logic [CW-1:0] low_cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_fire = 1'b0;
        if (!oe_n) begin
            // output enable low blocks the write and breaks the run
            st_d.low_cnt = '0;
        end else if (!we_n) begin
            if (st_q.low_cnt != CW'(WE_MIN_CYC))
                st_d.low_cnt = st_q.low_cnt + 1'b1;
        end else begin
            wr_fire      = (st_q.low_cnt >= CW'(WE_MIN_CYC));
            st_d.low_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wse_por_lock.sv
// Write lockout after supply-good or reset: locked until POR_CYC cycles of pwr_ok.
module wse_por_lock #(
    parameter int POR_CYC = 1250000,
    localparam int CW = $clog2(POR_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic locked
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_ok)
            st_d.cnt = '0;
        else if (st_q.cnt != CW'(POR_CYC))
            st_d.cnt = st_q.cnt + 1'b1;
        locked = (st_q.cnt != CW'(POR_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wse_op_timer.sv
// Launches an operation and holds busy for a duration chosen by its type.
module wse_op_timer
    import wse_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int PROG_CYC  = 25000,
    parameter int ERASE_CYC = 37500000,
    localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
    localparam int CW       = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              try_start,
    input  logic              locked,
    input  wse_op_e           op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              launch,
    output logic              busy,
    output logic              done,
    output wse_op_e           busy_op,
    output logic [ADDR_W-1:0] busy_addr,
    output logic [DATA_W-1:0] busy_data
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CW-1:0]     cnt;
        wse_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        launch    = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (try_start && !locked && op_in != OP_RSVD) begin
            launch    = 1'b1;
            st_d.busy = 1'b1;
            st_d.op   = op_in;
            st_d.addr = addr_in;
            st_d.data = data_in;
            st_d.cnt  = (op_in == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign busy_op   = st_q.op;
    assign busy_addr = st_q.addr;
    assign busy_data = st_q.data;

endmodule

// File: rtl/wse_status_gen.sv
// Read path: array byte when idle, polling and toggle bits while busy.
module wse_status_gen
    import wse_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic              launch,
    input  wse_op_e           busy_op,
    input  logic              data_msb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_oe;
        logic              tog;
    } st_t;

    st_t  st_d, st_q;
    logic poll_bit;

    always_comb begin
        st_d       = st_q;
        poll_bit   = (busy_op == OP_PROG) ? ~data_msb : 1'b0;
        st_d.rd_oe = rd_stb;
        if (rd_stb) begin
            if (busy)
                st_d.rd_data = {poll_bit, st_q.tog, arr_data[DATA_W-3:0]};
            else
                st_d.rd_data = arr_data;
        end
        if (launch)
            st_d.tog = 1'b0;
        else if (rd_stb && busy)
            st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign rd_oe   = st_q.rd_oe;

endmodule

// File: rtl/wse_engine.sv
module wse_engine
    import wse_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter int WE_MIN_CYC = 4,
    parameter int PROG_CYC   = 25000,
    parameter int ERASE_CYC  = 37500000,
    parameter int POR_CYC    = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              start_req,
    input  logic [1:0]        start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] busy_addr,
    output logic [DATA_W-1:0] busy_data
);

    logic    wr_fire_w;
    logic    locked_w;
    logic    launch_w;
    wse_op_e busy_op_w;

    wse_we_filter #(.WE_MIN_CYC(WE_MIN_CYC)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .wr_fire (wr_fire_w)
    );

    wse_por_lock #(.POR_CYC(POR_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .locked (locked_w)
    );

    wse_op_timer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .try_start (wr_fire_w & start_req),
        .locked    (locked_w),
        .op_in     (wse_op_e'(start_op)),
        .addr_in   (start_addr),
        .data_in   (start_data),
        .launch    (launch_w),
        .busy      (busy),
        .done      (done),
        .busy_op   (busy_op_w),
        .busy_addr (busy_addr),
        .busy_data (busy_data)
    );

    wse_status_gen #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .busy     (busy),
        .launch   (launch_w),
        .busy_op  (busy_op_w),
        .data_msb (busy_data[DATA_W-1]),
        .arr_data (arr_data),
        .rd_data  (rd_data),
        .rd_oe    (rd_oe)
    );

endmodule

// File: rtl/wse_engine_chk.sv
module wse_engine_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_stb,
    input logic              rd_oe,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] busy_addr,
    input logic              locked,
    input logic [1:0]        busy_op
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                           // R6

    AST_NO_LAUNCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!locked));                            // R2

    AST_BUSY_MIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);                                      // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(busy_addr));              // R7

    AST_OE_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(rd_stb));                                   // R12

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && $past(busy) && $past(busy_op) != 2'b00) |-> !rd_data[DATA_W-1]); // R9

endmodule

bind wse_engine wse_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rd_stb    (rd_stb),
    .rd_oe     (rd_oe),
    .rd_data   (rd_data),
    .busy_addr (busy_addr),
    .locked    (locked_w),
    .busy_op   (busy_op_w)
);

// File: tb/wse_engine_bench.sv
module wse_engine_bench;
    localparam int AW    = 18;
    localparam int DW    = 8;
    localparam int PROG  = 20;
    localparam int ERASE = 50;
    localparam int POR   = 30;
    localparam int WEM   = 4;

    logic          clk = 1'b0;
    logic          rst_n, pwr_ok, we_n, oe_n, start_req, rd_stb;
    logic [1:0]    start_op;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] start_data, arr_data;
    logic [DW-1:0] rd_data, busy_data;
    logic [AW-1:0] busy_addr;
    logic          rd_oe, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    wse_engine #(
        .ADDR_W(AW), .DATA_W(DW), .WE_MIN_CYC(WEM),
        .PROG_CYC(PROG), .ERASE_CYC(ERASE), .POR_CYC(POR)
    ) u_wse_engine (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .we_n(we_n), .oe_n(oe_n),
        .start_req(start_req), .start_op(start_op), .start_addr(start_addr),
        .start_data(start_data), .rd_stb(rd_stb), .arr_data(arr_data),
        .rd_data(rd_data), .rd_oe(rd_oe), .busy(busy), .done(done),
        .busy_addr(busy_addr), .busy_data(busy_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read results in issue order
    always @(negedge clk) begin
        if (rd_oe === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected rd_oe", 32'(rd_data), 32'hx);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, 32'(rd_data), 32'(e));
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic rd(input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic wr(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int low, input logic oe_lo, input logic oe_fire,
                      input bit rd_fire, input logic [DW-1:0] rd_exp, input string rd_tag);
        start_req  = 1'b1;
        start_op   = op;
        start_addr = a;
        start_data = d;
        oe_n       = oe_lo;
        we_n       = 1'b0;
        repeat (low) @(negedge clk);
        we_n = 1'b1;
        oe_n = oe_fire;
        if (rd_fire) begin
            exp_q.push_back(rd_exp);
            tag_q.push_back(rd_tag);
            rd_stb = 1'b1;
        end
        @(negedge clk);
        rd_stb    = 1'b0;
        start_req = 1'b0;
        oe_n      = 1'b1;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy === 1'b1 && k < 2000) begin
            k++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic measure(input int expn, input string req);
        int n = 0;
        while (busy === 1'b1 && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk(n == expn, req, 32'(n), 32'(expn));
        chk(done === 1'b1, "R6 done at end", 32'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R6 done one cycle", 32'(done), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int dn;
        rst_n = 1'b0; pwr_ok = 1'b1; we_n = 1'b1; oe_n = 1'b1; start_req = 1'b0;
        rd_stb = 1'b0; start_op = 2'b00; start_addr = '0; start_data = '0; arr_data = 8'h3C;
        repeat (2) @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        // R1: reset state, read strobe ignored
        chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
        chk(done === 1'b0, "R1 done", 32'(done), 0);
        chk(rd_oe === 1'b0, "R1 rd_oe", 32'(rd_oe), 0);
        chk(rd_data === 8'h00, "R1 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;

        // R2: lockout right after reset
        wr(2'b00, 18'h00010, 8'h11, 5, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R2 locked after reset", 32'(busy), 0);
        repeat (POR + 10) @(negedge clk);

        // R3: run one short of the minimum
        wr(2'b00, 18'h00020, 8'h22, WEM - 1, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R3 short strobe", 32'(busy), 0);
        // R4: oe_n low through the low run, then at the rising edge only
        wr(2'b00, 18'h00030, 8'h33, WEM + 2, 1'b0, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R4 oe low in run", 32'(busy), 0);
        wr(2'b00, 18'h00031, 8'h33, WEM + 2, 1'b1, 1'b0, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R4 oe low at fire", 32'(busy), 0);
        // R13: reserved code
        wr(2'b11, 18'h00040, 8'h44, WEM + 1, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R13 reserved op", 32'(busy), 0);

        // R3 boundary + R5 program duration
        wr(2'b00, 18'h3C000, 8'h5A, WEM, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b1, "R3 exact minimum", 32'(busy), 1);
        chk(busy_addr === 18'h3C000, "R7 addr latched", 32'(busy_addr), 32'h3C000);
        chk(busy_data === 8'h5A, "R7 data latched", 32'(busy_data), 32'h5A);
        measure(PROG, "R5 program cycles");

        // R8 R10: program polling, data bit7 = 0
        wr(2'b00, 18'h00100, 8'h5A, WEM, 1'b1, 1'b1, 1'b0, 8'h00, "");
        rd(8'hBC, "R8 R10 read1");
        rd(8'hFC, "R8 R10 read2");
        rd(8'hBC, "R8 R10 read3");
        wait_idle();
        rd(8'h3C, "R11 idle after program");

        // launch/read collision; toggle was left at 1
        arr_data = 8'hC3;
        wr(2'b00, 18'h00200, 8'hA5, WEM, 1'b1, 1'b1, 1'b1, 8'hC3, "R11 read on launch edge");
        rd(8'h03, "R10 toggle cleared at launch");
        rd(8'h43, "R10 toggle flips");
        // R7: start while busy ignored
        wr(2'b01, 18'h00123, 8'h77, WEM + 1, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy_addr === 18'h00200, "R7 addr held", 32'(busy_addr), 32'h00200);
        chk(busy_data === 8'hA5, "R7 data held", 32'(busy_data), 32'hA5);
        wait_idle();
        chk(busy_addr === 18'h00200, "R7 no relaunch", 32'(busy_addr), 32'h00200);

        // R9: chip erase polling, then completion/read collision
        arr_data = 8'hFF;
        wr(2'b10, 18'h00000, 8'hFF, WEM, 1'b1, 1'b1, 1'b0, 8'h00, "");
        rd(8'h3F, "R9 erase read1");
        rd(8'h7F, "R9 erase read2");
        repeat (ERASE - 3) @(negedge clk);
        chk(busy === 1'b1, "R5 last busy cycle", 32'(busy), 1);
        rd(8'h3F, "R9 read at completion edge");
        chk(done === 1'b1 && busy === 1'b0, "R6 done with last read", 32'({done, busy}), 32'b10);
        @(negedge clk);
        rd(8'hFF, "R11 idle after erase");

        // R5 sector erase duration
        wr(2'b01, 18'h20000, 8'h00, WEM + 3, 1'b1, 1'b1, 1'b0, 8'h00, "");
        measure(ERASE, "R5 sector erase cycles");

        // R2: supply drop restarts lockout
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        wr(2'b00, 18'h00300, 8'h01, WEM, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b0, "R2 locked after pwr drop", 32'(busy), 0);
        repeat (POR + 5) @(negedge clk);

        // R14: reset aborts a running program
        wr(2'b00, 18'h00400, 8'h02, WEM, 1'b1, 1'b1, 1'b0, 8'h00, "");
        chk(busy === 1'b1, "R14 launched", 32'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && rd_oe === 1'b0, "R14 aborted", 32'({busy, rd_oe}), 0);
        rst_n = 1'b1;
        dn = 0;
        repeat (PROG + 5) begin
            @(negedge clk);
            if (done === 1'b1) dn++;
        end
        chk(dn == 0, "R14 no done after abort", 32'(dn), 0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all reads returned", 32'(exp_q.size()), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule